// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

This block is a clock-synchronous static memory with a two-bit burst address counter. On each rising clock edge it takes in the address, the write data and every control input, and it turns them into one of three kinds of cycle. A deselect closes any burst. A burst start loads the external address. A continue or suspend cycle either advances the burst counter or holds it, and it reads or writes at the resulting address. Writes can cover every byte lane at once or only selected lanes. Each lane is nine bits wide.

Reads leave the core on a data bus with a valid flag, so no tristate is needed. A mode input chooses between flow-through reads, which show the data straight after the capturing edge, and pipelined reads, which pass through an output register and show the data one edge later. The output turn-off follows the single-cycle-deselect rule: a deselect or a write switches the drivers off with the same latency as read data. An asynchronous output enable can mask the outputs at any moment. A sleep input freezes the core without losing the stored contents. After sleep is released, a parameterised number of edges pass before commands are accepted again.

The control FSM has four states. `ST_IDLE` means deselected. `ST_BURST` means a burst is open. `ST_SLEEP` covers the time the sleep input is high. `ST_WAKE` counts the recovery edges. The transitions are:
- Any state goes to ST_SLEEP when sleep is high.
- ST_SLEEP goes to ST_WAKE when sleep is low, or straight to ST_IDLE when the recovery length is one.
- ST_WAKE goes to ST_IDLE on its last recovery edge.
- ST_IDLE or ST_BURST goes to ST_BURST on a burst start.
- ST_IDLE or ST_BURST goes to ST_IDLE on a deselect.
- A continue or suspend cycle leaves the state unchanged. It accesses the array only in ST_BURST.

Top module: `sram_burst_core`

## Requirements
- R1: During and straight after reset, `rvalid` is 0 and `rdata` is all zeros.
- R2: The secondary enable is true only when `cs_hi`=1 and `cs_lo_n`=0. Any of these is a deselect with no array access:
  - `cs_n`=1 with `ld_sec_n`=0;
  - `cs_n`=0 with the secondary enable false and `ld_pri_n`=0;
  - `cs_n`=0 with the secondary enable false, `ld_pri_n`=1 and `ld_sec_n`=0.
  
  With `cs_n`=1, a low `ld_pri_n` is ignored, and the cycle is a continue or a suspend.
- R3: A cycle with `cs_n`=0, the secondary enable true and `ld_pri_n`=0 starts a read burst at `addr`, whatever the write inputs are.
- R4: A cycle with `cs_n`=0, the secondary enable true, `ld_pri_n`=1 and `ld_sec_n`=0 starts a burst at `addr`. It is a write when the write decode (R7) selects any lane, and a read otherwise.
- R5: When neither strobe is active, `step_n`=0 moves to the next burst address and `step_n`=1 stays on the current one. Each such cycle reads or writes as the write decode says. Outside an open burst (after a deselect), these cycles do nothing.
- R6: The low two address bits of access k of a burst (k=0..3, wrapping to 0 after the fourth) are (base+k) mod 4 when `linear_mode`=1, and base XOR k when `linear_mode`=0. The upper bits stay fixed.
- R7: When `wr_all_n`=0, all lanes are written. Otherwise, when `wr_byte_n`=0, lane i is written exactly when `lane_n[i]`=0. Lane i is `wdata[9i+8:9i]`. With `wr_byte_n`=0 and all `lane_n` high, the cycle is a read.
- R8: With `pipe_mode`=0, a read captured at edge n drives `rvalid`=1 and the addressed word after edge n, until edge n+1.
- R9: With `pipe_mode`=1, a read captured at edge n drives its data after edge n+1, until edge n+2.
- R10: A deselect or a write captured at edge n turns `rvalid` off with the same latency as read data: after edge n in flow-through mode, and after edge n+1 in pipelined mode.
- R11: `oe_n`=1 forces `rvalid`=0 and `rdata`=0 at once, without waiting for a clock edge. `oe_n`=0 brings back only outputs that a read has made active.
- R12: An edge that samples `sleep`=1 performs no access and keeps the stored contents. The outputs turn off as they would for a deselect.
- R13: After sleep, the first WAKE_CYC edges that sample `sleep`=0 ignore all commands. The next edge is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Primary chip select, active low |
| cs_hi | input | 1 | Secondary select, active high |
| cs_lo_n | input | 1 | Secondary select, active low |
| ld_pri_n | input | 1 | Priority load strobe; its burst starts are always reads |
| ld_sec_n | input | 1 | Secondary load strobe; its burst starts are read or write |
| step_n | input | 1 | Burst advance, active low |
| addr | input | AW | External word address |
| wr_all_n | input | 1 | Write every lane, active low |
| wr_byte_n | input | 1 | Lane-select write enable, active low |
| lane_n | input | NB | Per-lane write selects, active low |
| wdata | input | NB*9 | Write data |
| pipe_mode | input | 1 | 1 = pipelined reads, 0 = flow-through |
| linear_mode | input | 1 | 1 = linear burst order, 0 = interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep request, contents retained |
| rdata | output | NB*9 | Read data, zero when not valid |
| rvalid | output | 1 | Read data is being driven |

## Verification
Every result is due at a fixed edge after its stimulus:
- A write reaches the array at the edge that captures it.
- Flow-through read data is due right after the capturing edge. Pipelined read data is due one edge later.
- Output turn-off after a deselect, a write or sleep follows the same two latencies.
- The output enable acts within the same clock phase.

The bench drives inputs on the falling edge. Its reference model advances one step at each rising edge from the inputs it drove. The outputs are compared one nanosecond after that edge, so every register on the path has already settled. The output enable is also toggled in the middle of a cycle and checked a fraction of a nanosecond later. Whether a write took place or was correctly ignored shows up in the data of the following reads.

// File: rtl/sram_burst_pkg.sv
`timescale 1ns/100ps
package sram_burst_pkg;

    localparam int LANE_W = 9;

    typedef enum logic [1:0] {
        OP_DESEL,
        OP_BEGIN,
        OP_NEXT,
        OP_HOLD
    } op_e;

    typedef enum logic [1:0] {
        ST_SLEEP,
        ST_WAKE,
        ST_IDLE,
        ST_BURST
    } state_e;

    // low address bits for burst access number 'step' from 'base'
    function automatic logic [1:0] burst_lsb(logic [1:0] base, logic [1:0] step, logic linear);
        return linear ? 2'(base + step) : (base ^ step);
    endfunction

endpackage

// File: rtl/sram_cmd_decode.sv
`timescale 1ns/100ps
module sram_cmd_decode
    import sram_burst_pkg::*;
#(
    parameter int NB = 4
) (
    input  logic          cs_n,
    input  logic          cs_hi,
    input  logic          cs_lo_n,
    input  logic          ld_pri_n,
    input  logic          ld_sec_n,
    input  logic          step_n,
    input  logic          wr_all_n,
    input  logic          wr_byte_n,
    input  logic [NB-1:0] lane_n,
    output op_e           op,
    output logic [NB-1:0] lanes
);

    logic          sec_ok;
    logic [NB-1:0] wr_sel;

    always_comb begin
        sec_ok = cs_hi & ~cs_lo_n;
        if (!wr_all_n) begin
            wr_sel = '1;
        end else if (!wr_byte_n) begin
            wr_sel = ~lane_n;
        end else begin
            wr_sel = '0;
        end

        lanes = wr_sel;
        if (!cs_n && !ld_pri_n) begin
            // priority strobe: start of a read burst, write inputs ignored
            op    = sec_ok ? OP_BEGIN : OP_DESEL;
            lanes = '0;
        end else if (!ld_sec_n) begin
            op = (!cs_n && sec_ok) ? OP_BEGIN : OP_DESEL;
        end else begin
            op = step_n ? OP_HOLD : OP_NEXT;
        end
    end

endmodule

// File: rtl/sram_burst_seq.sv
`timescale 1ns/100ps
module sram_burst_seq
    import sram_burst_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          advance,
    input  logic          linear,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] acc_addr
);

    logic [AW-3:0] upper_q;
    logic [1:0]    base_q;
    logic [1:0]    step_q;
    logic [1:0]    step_use;

    always_comb begin
        step_use = advance ? 2'(step_q + 2'd1) : step_q;
        if (load) begin
            acc_addr = addr_in;
        end else begin
            acc_addr = {upper_q, burst_lsb(base_q, step_use, linear)};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upper_q <= '0;
            base_q  <= '0;
            step_q  <= '0;
        end else if (load) begin
            upper_q <= addr_in[AW-1:2];
            base_q  <= addr_in[1:0];
            step_q  <= '0;
        end else if (advance) begin
            step_q  <= step_use;
        end
    end

endmodule

// File: rtl/sram_store.sv
`timescale 1ns/100ps
module sram_store
    import sram_burst_pkg::*;
#(
    parameter int NB    = 4,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int DW   = NB * LANE_W
) (
    input  logic          clk,
    input  logic [NB-1:0] we_lanes,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    for (genvar g = 0; g < NB; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (we_lanes[g]) begin
                cells[waddr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = cells[raddr];
    end

endmodule

// File: rtl/sram_rd_path.sv
`timescale 1ns/100ps
module sram_rd_path #(
    parameter int DW = 36,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc,
    input  logic          rd_fire,
    input  logic [AW-1:0] acc_addr,
    input  logic [DW-1:0] arr_data,
    input  logic          pipe_mode,
    input  logic          oe_n,
    output logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);

    logic          ft_q;
    logic          pf_q;
    logic [DW-1:0] pd_q;
    logic          drive;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raddr <= '0;
            ft_q  <= 1'b0;
            pf_q  <= 1'b0;
            pd_q  <= '0;
        end else begin
            if (acc) begin
                raddr <= acc_addr;
            end
            ft_q <= rd_fire;
            pf_q <= ft_q;
            pd_q <= arr_data;
        end
    end

    always_comb begin
        drive  = pipe_mode ? pf_q : ft_q;
        rvalid = drive & ~oe_n;
        if (rvalid) begin
            rdata = pipe_mode ? pd_q : arr_data;
        end else begin
            rdata = '0;
        end
    end

endmodule

// File: rtl/sram_burst_core.sv
`timescale 1ns/100ps
module sram_burst_core
    import sram_burst_pkg::*;
#(
    parameter int NB       = 4,
    parameter int DEPTH    = 64,
    parameter int WAKE_CYC = 3,
    localparam int AW      = $clog2(DEPTH),
    localparam int DW      = NB * LANE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          cs_hi,
    input  logic          cs_lo_n,
    input  logic          ld_pri_n,
    input  logic          ld_sec_n,
    input  logic          step_n,
    input  logic [AW-1:0] addr,
    input  logic          wr_all_n,
    input  logic          wr_byte_n,
    input  logic [NB-1:0] lane_n,
    input  logic [DW-1:0] wdata,
    input  logic          pipe_mode,
    input  logic          linear_mode,
    input  logic          oe_n,
    input  logic          sleep,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);

    localparam int WCW = $clog2(WAKE_CYC + 1);

    op_e           op;
    logic [NB-1:0] dec_lanes;
    state_e        state_q, state_d;
    logic [WCW-1:0] wake_q, wake_d;

    logic          live, begin_go, cont_go, acc, rd_fire, seq_step;
    logic [NB-1:0] wr_lanes;
    logic [AW-1:0] acc_addr;
    logic [AW-1:0] raddr;
    logic [DW-1:0] arr_data;

    sram_cmd_decode #(.NB(NB)) u_dec (
        .cs_n      (cs_n),
        .cs_hi     (cs_hi),
        .cs_lo_n   (cs_lo_n),
        .ld_pri_n  (ld_pri_n),
        .ld_sec_n  (ld_sec_n),
        .step_n    (step_n),
        .wr_all_n  (wr_all_n),
        .wr_byte_n (wr_byte_n),
        .lane_n    (lane_n),
        .op        (op),
        .lanes     (dec_lanes)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        wake_d  = wake_q;
        unique case (state_q)
            ST_SLEEP: begin
                if (WAKE_CYC <= 1) begin
                    state_d = ST_IDLE;
                end else begin
                    state_d = ST_WAKE;
                    wake_d  = WCW'(WAKE_CYC - 1);
                end
            end
            ST_WAKE: begin
                if (wake_q <= WCW'(1)) begin
                    state_d = ST_IDLE;
                end else begin
                    wake_d = wake_q - WCW'(1);
                end
            end
            ST_IDLE, ST_BURST: begin
                if (op == OP_DESEL) begin
                    state_d = ST_IDLE;
                end else if (op == OP_BEGIN) begin
                    state_d = ST_BURST;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (sleep) begin
            state_d = ST_SLEEP;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wake_q  <= '0;
        end else begin
            state_q <= state_d;
            wake_q  <= wake_d;
        end
    end

    // outputs of the FSM
    always_comb begin
        live     = !sleep && (state_q == ST_IDLE || state_q == ST_BURST);
        begin_go = live && (op == OP_BEGIN);
        cont_go  = live && (state_q == ST_BURST) && (op == OP_NEXT || op == OP_HOLD);
        acc      = begin_go || cont_go;
        seq_step = cont_go && (op == OP_NEXT);
        wr_lanes = acc ? dec_lanes : '0;
        rd_fire  = acc && (dec_lanes == '0);
    end

    sram_burst_seq #(.AW(AW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (begin_go),
        .advance  (seq_step),
        .linear   (linear_mode),
        .addr_in  (addr),
        .acc_addr (acc_addr)
    );

    sram_store #(.NB(NB), .DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .we_lanes (wr_lanes),
        .waddr    (acc_addr),
        .wdata    (wdata),
        .raddr    (raddr),
        .rdata    (arr_data)
    );

    sram_rd_path #(.DW(DW), .AW(AW)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (acc),
        .rd_fire   (rd_fire),
        .acc_addr  (acc_addr),
        .arr_data  (arr_data),
        .pipe_mode (pipe_mode),
        .oe_n      (oe_n),
        .raddr     (raddr),
        .rdata     (rdata),
        .rvalid    (rvalid)
    );

endmodule

// File: rtl/sram_burst_core_chk.sv
`timescale 1ns/100ps
module sram_burst_core_chk #(
    parameter int NB = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic          cs_hi,
    input logic          cs_lo_n,
    input logic          ld_pri_n,
    input logic          pipe_mode,
    input logic          oe_n,
    input logic          sleep,
    input logic          rvalid,
    input logic [NB-1:0] wr_lanes
);

    logic pri_desel;
    assign pri_desel = !cs_n && !ld_pri_n && !(cs_hi && !cs_lo_n);

    p_oe_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !rvalid);

    p_pri_read_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !ld_pri_n) |-> (wr_lanes == '0));

    p_ft_desel_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pri_desel) && !pipe_mode) |-> !rvalid);

    p_pipe_desel_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pri_desel, 2) && pipe_mode) |-> !rvalid);

    p_sleep_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sleep) && $past(sleep, 2)) |-> !rvalid);

endmodule

bind sram_burst_core sram_burst_core_chk #(.NB(NB)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .cs_hi     (cs_hi),
    .cs_lo_n   (cs_lo_n),
    .ld_pri_n  (ld_pri_n),
    .pipe_mode (pipe_mode),
    .oe_n      (oe_n),
    .sleep     (sleep),
    .rvalid    (rvalid),
    .wr_lanes  (wr_lanes)
);

// File: tb/test_sram_burst_core.sv
`timescale 1ns/100ps
module test_sram_burst_core;

    localparam int NB = 4;
    localparam int DEPTH = 64;
    localparam int WAKE = 3;
    localparam int AW = 6;
    localparam int DW = 36;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1, cs_hi = 1'b1, cs_lo_n = 1'b0;
    logic          ld_pri_n = 1'b1, ld_sec_n = 1'b0, step_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          wr_all_n = 1'b1, wr_byte_n = 1'b1;
    logic [NB-1:0] lane_n = '1;
    logic [DW-1:0] wdata = '0;
    logic          pipe_mode = 1'b0, linear_mode = 1'b1, oe_n = 1'b0, sleep = 1'b0;
    logic [DW-1:0] rdata;
    logic          rvalid;

    sram_burst_core #(.NB(NB), .DEPTH(DEPTH), .WAKE_CYC(WAKE)) i_sram_burst_core (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n),
        .ld_pri_n(ld_pri_n), .ld_sec_n(ld_sec_n), .step_n(step_n), .addr(addr),
        .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_n(lane_n), .wdata(wdata),
        .pipe_mode(pipe_mode), .linear_mode(linear_mode), .oe_n(oe_n), .sleep(sleep),
        .rdata(rdata), .rvalid(rvalid)
    );

    always #2 clk = ~clk;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    logic [DW-1:0] m_mem [DEPTH];
    int            m_state = 2;   // 0 sleep, 1 wake, 2 idle, 3 burst
    int            m_wcnt = 0;
    int            m_upper = 0, m_base = 0, m_k = 0, m_rdaddr = 0;
    bit            m_ft = 0, m_pf = 0;
    logic [DW-1:0] m_pd = '0;

    initial begin
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    end

    task automatic model_step();
        logic [DW-1:0] new_pd;
        bit            new_pf, sec, acc, is_rd, beg;
        logic [NB-1:0] mask;
        int            a;
        if (!rst_n) begin
            m_state = 2; m_ft = 0; m_pf = 0; m_pd = '0; m_rdaddr = 0;
            m_upper = 0; m_base = 0; m_k = 0; m_wcnt = 0;
            return;
        end
        new_pd = m_mem[m_rdaddr];
        new_pf = m_ft;
        acc = 0; is_rd = 0; a = 0;
        if (sleep) begin
            m_state = 0;
        end else if (m_state == 0) begin
            if (WAKE <= 1) m_state = 2;
            else begin m_state = 1; m_wcnt = WAKE - 1; end
        end else if (m_state == 1) begin
            if (m_wcnt <= 1) m_state = 2;
            else m_wcnt--;
        end else begin
            sec  = cs_hi && !cs_lo_n;
            mask = !wr_all_n ? '1 : (!wr_byte_n ? ~lane_n : '0);
            beg  = 0;
            if (!cs_n && !ld_pri_n) begin
                if (sec) begin beg = 1; mask = '0; end
                else m_state = 2;
            end else if (!ld_sec_n) begin
                if (!cs_n && sec) beg = 1;
                else m_state = 2;
            end else if (m_state == 3) begin
                if (!step_n) m_k = (m_k + 1) % 4;
                acc = 1;
            end
            if (beg) begin
                m_upper = int'(addr) / 4; m_base = int'(addr) % 4; m_k = 0;
                m_state = 3; acc = 1;
            end
            if (acc) begin
                a = m_upper * 4 + (linear_mode ? (m_base + m_k) % 4 : (m_base ^ m_k));
                for (int i = 0; i < NB; i++)
                    if (mask[i]) m_mem[a][i*9 +: 9] = wdata[i*9 +: 9];
                is_rd = (mask == '0);
                m_rdaddr = a;
            end
        end
        m_ft = is_rd;
        m_pf = new_pf;
        m_pd = new_pd;
    endtask

    always @(posedge clk) begin
        bit            ev;
        logic [DW-1:0] ed;
        model_step();
        #1;
        if (!done) begin
            ev = (pipe_mode ? m_pf : m_ft) && !oe_n;
            ed = ev ? (pipe_mode ? m_pd : m_mem[m_rdaddr]) : '0;
            check(cur_req, DW'(rvalid), DW'(ev));
            check(cur_req, rdata, ed);
        end
    end

    // ---------------- stimulus helpers ----------------
    function automatic logic [DW-1:0] pat(int i);
        return (DW'(i) * 36'h0_0F0F_0F0F) ^ 36'h9_A5A5_A5A5;
    endfunction

    task automatic issue(logic c1, logic c2, logic c3, logic p, logic s, logic st,
                         int a, logic wa, logic wb, logic [NB-1:0] ln, logic [DW-1:0] d);
        cs_n = c1; cs_hi = c2; cs_lo_n = c3; ld_pri_n = p; ld_sec_n = s; step_n = st;
        addr = AW'(a); wr_all_n = wa; wr_byte_n = wb; lane_n = ln; wdata = d;
        @(negedge clk);
    endtask

    task automatic desel();
        issue(1, 1, 0, 1, 0, 1, 0, 1, 1, '1, '0);
    endtask
    task automatic wr_start(int a, logic [DW-1:0] d);
        issue(0, 1, 0, 1, 0, 1, a, 0, 1, '1, d);
    endtask
    task automatic rd_start(int a);
        issue(0, 1, 0, 1, 0, 1, a, 1, 1, '1, '0);
    endtask
    task automatic pri_start(int a);
        // write inputs active on purpose: must be ignored (R3)
        issue(0, 1, 0, 0, 1, 1, a, 0, 0, '0, pat(99));
    endtask
    task automatic cont_rd(logic st);
        issue(1, 1, 0, 1, 1, st, 0, 1, 1, '1, '0);
    endtask
    task automatic cont_wr(logic st, logic [DW-1:0] d);
        issue(1, 1, 0, 1, 1, st, 0, 0, 1, '1, d);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // ---------------- sequence ----------------
    initial begin
        cur_req = "R1";
        repeat (3) @(negedge clk);
        check("R1", DW'(rvalid), '0);
        check("R1", rdata, '0);
        rst_n = 1'b1;
        desel();
        check("R1", DW'(rvalid), '0);

        cur_req = "R4";   // burst writes through the secondary strobe, fill 0..15
        for (int b = 0; b < 4; b++) begin
            wr_start(b * 4, pat(b * 4));
            for (int j = 1; j < 4; j++) cont_wr(1'b0, pat(b * 4 + j));
        end
        desel();

        cur_req = "R8";   // flow-through reads
        rd_start(6);
        cont_rd(1'b0);
        desel();

        cur_req = "R3";   // priority start is a read despite write inputs
        pri_start(9);
        desel();
        rd_start(9);
        desel();

        cur_req = "R6";   // linear order from base 1: 13,14,15,12,13
        pri_start(13);
        for (int i = 0; i < 4; i++) cont_rd(1'b0);
        desel();
        linear_mode = 1'b0;   // interleaved: 13,12,15,14,13
        pri_start(13);
        for (int i = 0; i < 4; i++) cont_rd(1'b0);
        desel();
        linear_mode = 1'b1;

        cur_req = "R5";   // suspend and advance, then no effect when deselected
        pri_start(2);
        cont_rd(1'b1);
        cont_rd(1'b1);
        cont_rd(1'b0);
        desel();
        cont_wr(1'b0, pat(77));
        cont_wr(1'b1, pat(78));
        rd_start(0);
        rd_start(3);
        desel();

        cur_req = "R7";   // lane writes
        wr_start(20, pat(20));
        issue(0, 1, 0, 1, 0, 1, 20, 1, 0, 4'b1010, pat(55));
        rd_start(20);
        issue(0, 1, 0, 1, 0, 1, 20, 1, 0, 4'b1111, pat(56));
        issue(0, 1, 0, 1, 0, 1, 20, 0, 1, 4'b1111, pat(57));
        rd_start(20);
        desel();

        cur_req = "R2";   // enable decode
        issue(0, 0, 0, 0, 1, 1, 10, 1, 1, '1, '0);
        cont_wr(1'b0, pat(60));
        issue(0, 1, 1, 1, 0, 1, 10, 0, 1, '1, pat(61));
        issue(1, 1, 0, 1, 0, 1, 11, 0, 1, '1, pat(62));
        rd_start(10);
        rd_start(11);
        pri_start(4);
        issue(1, 1, 0, 0, 1, 0, 0, 1, 1, '1, '0);
        desel();

        cur_req = "R9";   // pipelined reads
        pipe_mode = 1'b1;
        rd_start(1);
        cont_rd(1'b0);
        cont_rd(1'b0);
        desel();
        desel();

        cur_req = "R10";  // deselect and write turn-off latency
        rd_start(5);
        desel();
        desel();
        rd_start(6);
        wr_start(30, pat(30));
        rd_start(30);
        desel();
        desel();
        pipe_mode = 1'b0;
        rd_start(7);
        wr_start(31, pat(31));
        rd_start(31);
        desel();

        cur_req = "R11";  // asynchronous output enable
        rd_start(8);
        oe_n = 1'b1;
        #0.3;
        check("R11", DW'(rvalid), '0);
        check("R11", rdata, '0);
        oe_n = 1'b0;
        #0.3;
        check("R11", DW'(rvalid), DW'(1));
        check("R11", rdata, pat(8));
        desel();
        oe_n = 1'b1;
        rd_start(9);
        oe_n = 1'b0;
        desel();

        cur_req = "R12";  // sleep keeps contents and ignores writes
        rd_start(1);
        sleep = 1'b1;
        wr_start(1, pat(88));
        wr_start(1, pat(89));
        wr_start(2, pat(90));

        cur_req = "R13";  // recovery edges ignore commands
        sleep = 1'b0;
        wr_start(1, pat(91));
        wr_start(2, pat(92));
        wr_start(3, pat(93));
        wr_start(24, pat(24));
        rd_start(1);
        rd_start(2);
        rd_start(3);
        rd_start(24);
        desel();
        desel();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule